// File: doc/BRIEF.md
# External Interrupt Pin Qualifier

This block turns a raw, asynchronous, active-low interrupt pin into a clean one-cycle event for an interrupt controller. The pin first crosses into the clock domain through a short chain of flip-flops that capture on the falling clock edge. A small shift register then keeps the most recent synchronized samples. Pattern logic inspects that history, and the verdict is registered on the rising edge, where the controller's flag-set logic expects it.

Two qualification modes are available. In level mode an event needs a high sample followed by a run of low samples of a set length, so glitches and short pulses are filtered out. In strobe mode a single-cycle low strobe is enough, but a strobe only counts if it follows a minimum run of high samples. A strobe that comes too soon after the previous one is discarded and reported on a separate one-cycle drop output. Storing flags and arbitrating between sources is left to the controller.

Top module: `irq_pin_qualifier`

## Requirements
- R1: The pin passes through two falling-edge flip-flops and then a falling-edge history stage, and the result is registered on the rising edge. If the first low of a qualifying run is applied just after rising edge n, `event_o` is high between rising edges n+5 and n+6, and is low in the cycles just before and just after.
- R2: In level mode (`strobe_mode` = 0), the sample sequence high, low, low, low produces one event.
- R3: In level mode, a low pulse lasting one or two clock periods produces no event.
- R4: In level mode, one qualifying low run produces exactly one event, however long the pin stays low after it.
- R5: In strobe mode (`strobe_mode` = 1), a high-to-low sample transition that follows at least three high samples produces one event. A single-cycle low is enough.
- R6: In strobe mode, a high-to-low transition that follows fewer than three high samples produces no event. Instead, `drop_o` pulses high for exactly one cycle.
- R7: `drop_o` is never high in level mode, and `event_o` and `drop_o` are never high in the same cycle.
- R8: While `rst` is high, both outputs read 0, and every history entry is loaded with the synchronized pin level. If the pin is held low through a reset of at least four cycles, no event follows the release of reset. If the pin is held high through reset, a strobe arriving right after release is accepted.
- R9: `event_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Synchronizer and history use the falling edge; outputs use the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Raw asynchronous active-low interrupt pin |
| strobe_mode | input | 1 | 0 selects level qualification, 1 selects strobe qualification with spacing |
| event_o | output | 1 | One-cycle qualified interrupt event |
| drop_o | output | 1 | One-cycle pulse when a strobe is rejected for short spacing |

## Verification
The hardest case to reach from the ports is a strobe rejection. It needs a low, then only one or two high samples, then another low, and all of this has to reach the history intact through the falling-edge synchronizer. The stimulus is a table of 16-bit pin patterns, each started from a fully settled high history and followed by a long idle tail. Event and drop pulses are counted over the whole window, so the count does not depend on latency. A separate directed sequence fixes the exact cycle of the event, and two reset sequences, one with the pin held low and one with it held high, check how the history is seeded.

// File: rtl/irqq_pkg.sv
package irqq_pkg;

    typedef enum logic {
        QUAL_LEVEL  = 1'b0,
        QUAL_STROBE = 1'b1
    } qual_mode_e;

    typedef struct packed {
        logic fire;
        logic reject;
    } qual_res_t;

    // history needs room for the longest pattern plus its leading high sample
    function automatic int hist_depth(input int low_run, input int gap_run);
        return ((low_run > gap_run) ? low_run : gap_run) + 1;
    endfunction

endpackage

// File: rtl/irqq_sync.sv
module irqq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(negedge clk) stage_q[0] <= din;
            end else begin : g_next
                always_ff @(negedge clk) stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqq_history.sv
module irqq_history #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] hist
);
    // bit 0 holds the newest sample
    always_ff @(negedge clk) begin
        if (rst) begin
            hist <= {DEPTH{din}};
        end else begin
            hist <= {hist[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/irqq_match.sv
module irqq_match
    import irqq_pkg::*;
#(
    parameter int LOW_RUN  = 3,
    parameter int GAP_RUN  = 3,
    parameter int DEPTH    = 4
) (
    input  logic [DEPTH-1:0] hist,
    input  qual_mode_e       mode,
    output qual_res_t        res
);
    logic level_hit;
    logic fall;
    logic gap_ok;

    assign level_hit = hist[LOW_RUN] && (hist[LOW_RUN-1:0] == '0);
    assign fall      = hist[1] && !hist[0];
    assign gap_ok    = &hist[GAP_RUN:1];

    always_comb begin
        res = '0;
        if (mode == QUAL_STROBE) begin
            res.fire   = fall && gap_ok;
            res.reject = fall && !gap_ok;
        end else begin
            res.fire   = level_hit;
        end
    end
endmodule

// File: rtl/irq_pin_qualifier.sv
module irq_pin_qualifier
    import irqq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_RUN     = 3,
    parameter int GAP_RUN     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic strobe_mode,
    output logic event_o,
    output logic drop_o
);
    localparam int DEPTH = hist_depth(LOW_RUN, GAP_RUN);

    logic             pin_sync;
    logic [DEPTH-1:0] hist;
    qual_res_t        res;
    qual_mode_e       mode;

    assign mode = qual_mode_e'(strobe_mode);

    irqq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pin_n),
        .dout (pin_sync)
    );

    irqq_history #(.DEPTH(DEPTH)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_sync),
        .hist (hist)
    );

    irqq_match #(.LOW_RUN(LOW_RUN), .GAP_RUN(GAP_RUN), .DEPTH(DEPTH)) u_match (
        .hist (hist),
        .mode (mode),
        .res  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            event_o <= 1'b0;
            drop_o  <= 1'b0;
        end else begin
            event_o <= res.fire;
            drop_o  <= res.reject;
        end
    end
endmodule

// File: rtl/irqq_chk.sv
module irqq_chk (
    input logic clk,
    input logic rst,
    input logic strobe_mode,
    input logic event_o,
    input logic drop_o
);
    // R9
    event_single_chk: assert property (@(posedge clk) disable iff (rst)
        event_o |=> !event_o);

    // R7
    out_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(event_o && drop_o));

    // R7
    drop_mode_chk: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> $past(strobe_mode));

    // R6
    drop_single_chk: assert property (@(posedge clk) disable iff (rst)
        drop_o |=> !drop_o);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!event_o && !drop_o));
endmodule

bind irq_pin_qualifier irqq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .strobe_mode (strobe_mode),
    .event_o     (event_o),
    .drop_o      (drop_o)
);

// File: tb/irq_pin_qualifier_tb_top.sv
module irq_pin_qualifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;
    localparam int TAIL       = 10;

    // {mode, 16-bit pin pattern sent MSB first, expected events, expected drops}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 16'b1111_0001_1111_1111, 4'd1, 4'd0},  // R2
        {1'b0, 16'b1111_0011_1111_1111, 4'd0, 4'd0},  // R3 two lows
        {1'b0, 16'b1110_1111_1111_1111, 4'd0, 4'd0},  // R3 one low
        {1'b0, 16'b1000_0000_0000_0000, 4'd1, 4'd0},  // R4 long low
        {1'b0, 16'b1000_1000_1111_1111, 4'd2, 4'd0},  // R2 back to back
        {1'b0, 16'b1100_0110_0001_1111, 4'd2, 4'd0},  // R4 runs of 3 and 4
        {1'b1, 16'b1111_0111_1111_1111, 4'd1, 4'd0},  // R5 single strobe
        {1'b1, 16'b1101_1101_1111_1111, 4'd2, 4'd0},  // R5 exact spacing
        {1'b1, 16'b1011_0111_1111_1111, 4'd1, 4'd1},  // R6 two highs
        {1'b1, 16'b1010_1111_1111_1111, 4'd1, 4'd1},  // R6 one high
        {1'b1, 16'b1000_0011_1111_1111, 4'd1, 4'd0},  // R5 long low strobe
        {1'b1, 16'b1010_1011_1111_1111, 4'd1, 4'd2}   // R6 two rejects
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_n = 1'b1;
    logic strobe_mode = 1'b0;
    logic event_o;
    logic drop_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_qualifier dut_i (
        .clk         (clk),
        .rst         (rst),
        .pin_n       (pin_n),
        .strobe_mode (strobe_mode),
        .event_o     (event_o),
        .drop_o      (drop_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: sample the outputs just after the rising edge, then drive the pin
    task automatic tick(input logic p, output logic e, output logic d);
        @(posedge clk);
        #1;
        e = event_o;
        d = drop_o;
        pin_n = p;
    endtask

    task automatic idle(input int n);
        logic e, d;
        for (int i = 0; i < n; i++) tick(1'b1, e, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic e, d;
        int ev, dr, seen;

        // R8 reset state
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, e, d);
            if (i > 0) check(e == 1'b0 && d == 1'b0, "R8 outputs in reset", {e, d}, 0);
        end
        rst = 1'b0;
        idle(8);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            strobe_mode = VEC[v][24];
            idle(2);
            ev = 0;
            dr = 0;
            for (int b = 15; b >= 0; b--) begin
                tick(VEC[v][8+b], e, d);
                ev += int'(e);
                dr += int'(d);
            end
            for (int t = 0; t < TAIL; t++) begin
                tick(1'b1, e, d);
                ev += int'(e);
                dr += int'(d);
            end
            check(ev == int'(VEC[v][7:4]), $sformatf("R2/R3/R4/R5 events vec %0d", v), ev, int'(VEC[v][7:4]));
            check(dr == int'(VEC[v][3:0]), $sformatf("R6/R7 drops vec %0d", v), dr, int'(VEC[v][3:0]));
        end

        // R1 exact latency in level mode: first low at call 0
        strobe_mode = 1'b0;
        idle(6);
        seen = 0;
        for (int c = 0; c < 12; c++) begin
            tick((c < 3) ? 1'b0 : 1'b1, e, d);
            if (c == 4) check(e == 1'b0, "R1 before event", e, 0);
            if (c == 5) check(e == 1'b1, "R1 event cycle", e, 1);
            if (c == 6) check(e == 1'b0, "R1 after event (R9)", e, 0);
            seen += int'(e);
        end
        check(seen == 1, "R1 single event", seen, 1);

        // R8 pin held low through reset gives no event
        tick(1'b0, e, d);
        rst = 1'b1;
        for (int i = 0; i < 5; i++) tick(1'b0, e, d);
        rst = 1'b0;
        ev = 0;
        for (int i = 0; i < 12; i++) begin
            tick(1'b0, e, d);
            ev += int'(e);
        end
        check(ev == 0, "R8 low through reset", ev, 0);
        // recovery after release
        idle(4);
        ev = 0;
        for (int i = 0; i < 14; i++) begin
            tick((i < 3) ? 1'b0 : 1'b1, e, d);
            ev += int'(e);
        end
        check(ev == 1, "R8 recovery R2", ev, 1);

        // R8 pin high through reset, strobe right after release
        strobe_mode = 1'b1;
        rst = 1'b1;
        for (int i = 0; i < 5; i++) tick(1'b1, e, d);
        rst = 1'b0;
        ev = 0;
        dr = 0;
        for (int i = 0; i < 12; i++) begin
            tick((i == 0) ? 1'b0 : 1'b1, e, d);
            ev += int'(e);
            dr += int'(d);
        end
        check(ev == 1, "R8 strobe after reset R5", ev, 1);
        check(dr == 0, "R8 no drop after reset", dr, 0);

        // R7 level mode with rapid single lows never drops
        strobe_mode = 1'b0;
        idle(4);
        dr = 0;
        for (int i = 0; i < 16; i++) begin
            tick(i[0], e, d);
            dr += int'(d);
        end
        idle(8);
        check(dr == 0, "R7 no drop in level mode", dr, 0);

        finish_run();
    end
endmodule